// File: doc/BRIEF.md
# Status Byte and Service Request Generator

This block builds the 8-bit summary status word of an instrument. Its inputs are two queue flags and the event and enable vectors of three lower status registers. It also holds a software-written mask that selects which summary bits may call for host attention. One bit of the status word is the master summary. It is set whenever any other status bit is set while its mask bit is also set.

A service request line goes high when a masked-in status bit changes from 0 to 1. A bit that stays high does not request again. The error-queue bit is the exception: a one-cycle "error entered" strobe re-arms it, so every new error entry can request service even while the queue is already non-empty. The request line stays high until the host pulses a clear input, or until no enabled status bit is still set.

Top module: `status_srq_top`

## Requirements
- R1: Status bits 1 and 0 always read as zero.
- R2: Status bit 2 equals the error-queue-not-empty input, and status bit 4 equals the message-available input.
- R3: Status bit 3 is set when any questionable event bit has its matching enable bit set. Bit 7 is formed the same way from the operation vectors, and bit 5 from the standard-event vectors.
- R4: Status bit 6 is set exactly when at least one of status bits 7, 5, 4, 3, 2 is set together with the same bit of the mask register.
- R5: A mask write stores the write data with bit 6 forced to zero. The read port shows the stored mask in the cycle after the write.
- R6: When a status bit other than bit 6 rises from 0 to 1 while its mask bit is set, the request output is high from the next clock edge.
- R7: A status bit that stays high produces no further request after the request has been cleared.
- R8: If mask bit 2 is set and the error queue is non-empty, an error-entered strobe raises the request at the next edge, even when status bit 2 was already high.
- R9: The request output falls at the next edge after a clear pulse, unless a new enabled rise occurs in that same cycle. It also falls at the next edge after status bit 6 reads zero.
- R10: A rising status bit whose mask bit is zero produces no request.
- R11: After reset, the mask register, the status word's summary bit and the request output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errQueueNotEmpty | input | 1 | Error queue holds at least one entry |
| errEntered | input | 1 | One-cycle strobe: a new entry went into the error queue |
| msgAvail | input | 1 | Output queue holds a readable message |
| quesEvent | input | QUES_W | Questionable register event bits |
| quesEnable | input | QUES_W | Questionable register enable bits |
| operEvent | input | OPER_W | Operation register event bits |
| operEnable | input | OPER_W | Operation register enable bits |
| stdEvent | input | STD_W | Standard event register bits |
| stdEnable | input | STD_W | Standard event enable bits |
| sreWrEn | input | 1 | Mask register write strobe |
| sreWrData | input | 8 | Mask register write data |
| sreRdData | output | 8 | Mask register contents |
| statusByte | output | 8 | Assembled status word |
| srqClear | input | 1 | Host clear pulse for the request |
| srqOut | output | 1 | Service request |

## Verification
The assertions assume two things about the inputs: the summary inputs hold steady between clock edges, and the error-entered strobe lasts at most one cycle. The properties tie the request to status bit 6 and to the rising edges of bits that the mask enables. They do not decide whether a higher-level repeat request is legitimate. The bench drives every input on the falling clock edge. It raises errEntered only for a single cycle, and only while the error queue is non-empty, so the strobe always stands for a real new entry. It also returns all inputs to idle between scenarios, so that leftover high bits do not disturb the next scenario's edge detection.

// File: rtl/sbsr_pkg.sv
`timescale 1ns/1ps
package sbsr_pkg;
  localparam int SB_W     = 8;
  localparam int ERR_BIT  = 2;
  localparam int QUES_BIT = 3;
  localparam int MSG_BIT  = 4;
  localparam int STD_BIT  = 5;
  localparam int MSS_BIT  = 6;
  localparam int OPER_BIT = 7;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadSre;
  } ctrlStrobe_t;
endpackage

// File: rtl/sbsr_datapath.sv
`timescale 1ns/1ps
module sbsr_datapath
  import sbsr_pkg::*;
#(
  parameter int QUES_W = 16,
  parameter int OPER_W = 16,
  parameter int STD_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SB_W-1:0]   sreWrData,
  input  logic              errQueueNotEmpty,
  input  logic              msgAvail,
  input  logic [QUES_W-1:0] quesEvent,
  input  logic [QUES_W-1:0] quesEnable,
  input  logic [OPER_W-1:0] operEvent,
  input  logic [OPER_W-1:0] operEnable,
  input  logic [STD_W-1:0]  stdEvent,
  input  logic [STD_W-1:0]  stdEnable,
  output logic [SB_W-1:0]   sreQ,
  output logic [SB_W-1:0]   sbNoMss,
  output logic              mss,
  output logic [SB_W-1:0]   statusByte
);
  localparam logic [SB_W-1:0] SRE_WMASK = ~(SB_W'(1) << MSS_BIT);

  logic quesSum, operSum, stdSum;

  assign quesSum = |(quesEvent & quesEnable);
  assign operSum = |(operEvent & operEnable);
  assign stdSum  = |(stdEvent & stdEnable);

  always_comb begin
    sbNoMss           = '0;
    sbNoMss[ERR_BIT]  = errQueueNotEmpty;
    sbNoMss[QUES_BIT] = quesSum;
    sbNoMss[MSG_BIT]  = msgAvail;
    sbNoMss[STD_BIT]  = stdSum;
    sbNoMss[OPER_BIT] = operSum;
  end

  assign mss = |(sbNoMss & sreQ);

  always_comb begin
    statusByte          = sbNoMss;
    statusByte[MSS_BIT] = mss;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sreQ <= '0;
    else if (strobe.loadSre)  sreQ <= sreWrData & SRE_WMASK;
  end
endmodule

// File: rtl/sbsr_control.sv
`timescale 1ns/1ps
module sbsr_control
  import sbsr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [SB_W-1:0] sbNoMss,
  input  logic [SB_W-1:0] sreQ,
  input  logic            mss,
  input  logic            errEntered,
  input  logic            srqClear,
  input  logic            sreWrEn,
  output ctrlStrobe_t     strobe,
  output logic            srqOut
);
  logic [SB_W-1:0] prevQ;
  logic [SB_W-1:0] riseVec;
  logic            anyRise;

  for (genvar b = 0; b < SB_W; b++) begin : g_rise
    if (b == MSS_BIT) begin : g_skip
      assign riseVec[b] = 1'b0;
    end else if (b == ERR_BIT) begin : g_err
      assign riseVec[b] = sreQ[b] & sbNoMss[b] & (errEntered | ~prevQ[b]);
    end else begin : g_plain
      assign riseVec[b] = sreQ[b] & sbNoMss[b] & ~prevQ[b];
    end
  end

  assign anyRise = |riseVec;
  assign strobe.loadSre = sreWrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      srqOut <= 1'b0;
    end else begin
      prevQ  <= sbNoMss;
      srqOut <= anyRise | (srqOut & ~srqClear & mss);
    end
  end
endmodule

// File: rtl/status_srq_top.sv
`timescale 1ns/1ps
module status_srq_top
  import sbsr_pkg::*;
#(
  parameter int QUES_W = 16,
  parameter int OPER_W = 16,
  parameter int STD_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errQueueNotEmpty,
  input  logic              errEntered,
  input  logic              msgAvail,
  input  logic [QUES_W-1:0] quesEvent,
  input  logic [QUES_W-1:0] quesEnable,
  input  logic [OPER_W-1:0] operEvent,
  input  logic [OPER_W-1:0] operEnable,
  input  logic [STD_W-1:0]  stdEvent,
  input  logic [STD_W-1:0]  stdEnable,
  input  logic              sreWrEn,
  input  logic [7:0]        sreWrData,
  output logic [7:0]        sreRdData,
  output logic [7:0]        statusByte,
  input  logic              srqClear,
  output logic              srqOut
);
  ctrlStrobe_t     strobe;
  logic [SB_W-1:0] sreQ, sbNoMss;
  logic            mss;

  sbsr_datapath #(.QUES_W(QUES_W), .OPER_W(OPER_W), .STD_W(STD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sreWrData(sreWrData),
    .errQueueNotEmpty(errQueueNotEmpty), .msgAvail(msgAvail),
    .quesEvent(quesEvent), .quesEnable(quesEnable),
    .operEvent(operEvent), .operEnable(operEnable),
    .stdEvent(stdEvent), .stdEnable(stdEnable),
    .sreQ(sreQ), .sbNoMss(sbNoMss), .mss(mss), .statusByte(statusByte)
  );

  sbsr_control u_ctl (
    .clk(clk), .rstN(rstN), .sbNoMss(sbNoMss), .sreQ(sreQ), .mss(mss),
    .errEntered(errEntered), .srqClear(srqClear), .sreWrEn(sreWrEn),
    .strobe(strobe), .srqOut(srqOut)
  );

  assign sreRdData = sreQ;
endmodule

// File: rtl/sbsr_checker.sv
`timescale 1ns/1ps
module sbsr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       errEntered,
  input logic       sreWrEn,
  input logic [7:0] sreWrData,
  input logic [7:0] sreRdData,
  input logic [7:0] statusByte,
  input logic       srqOut
);
  // R5: write data lands with bit 6 cleared
  assert_sre_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    sreWrEn |=> (sreRdData == ($past(sreWrData) & 8'hBF)));

  // R6: an enabled rise of the message bit raises the request
  assert_msg_rise_srq_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusByte[4]) && sreRdData[4]) |=> srqOut);

  // R6: a request only appears after the master summary was set
  assert_srq_needs_mss_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srqOut) |-> $past(statusByte[6]));

  // R8: a new error entry with bit 2 enabled raises the request
  assert_err_entry_srq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errEntered && sreRdData[2] && statusByte[2]) |=> srqOut);

  // R9: no enabled bit left means the request drops
  assert_srq_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[6] |=> !srqOut);
endmodule

bind status_srq_top sbsr_checker u_chk (
  .clk(clk), .rstN(rstN), .errEntered(errEntered), .sreWrEn(sreWrEn),
  .sreWrData(sreWrData), .sreRdData(sreRdData), .statusByte(statusByte),
  .srqOut(srqOut)
);

// File: tb/status_srq_top_tb.sv
`timescale 1ns/1ps
module status_srq_top_tb;
  localparam int QW = 16, OW = 16, SW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic errQueueNotEmpty = 0, errEntered = 0, msgAvail = 0;
  logic [QW-1:0] quesEvent = '0, quesEnable = '0;
  logic [OW-1:0] operEvent = '0, operEnable = '0;
  logic [SW-1:0] stdEvent = '0, stdEnable = '0;
  logic sreWrEn = 0;
  logic [7:0] sreWrData = '0;
  logic [7:0] sreRdData, statusByte;
  logic srqClear = 0;
  logic srqOut;

  int errors = 0;
  int checks = 0;
  logic [7:0] sreModel = '0;

  always #2.5 clk = ~clk;

  status_srq_top #(.QUES_W(QW), .OPER_W(OW), .STD_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .errQueueNotEmpty(errQueueNotEmpty),
    .errEntered(errEntered), .msgAvail(msgAvail),
    .quesEvent(quesEvent), .quesEnable(quesEnable),
    .operEvent(operEvent), .operEnable(operEnable),
    .stdEvent(stdEvent), .stdEnable(stdEnable),
    .sreWrEn(sreWrEn), .sreWrData(sreWrData), .sreRdData(sreRdData),
    .statusByte(statusByte), .srqClear(srqClear), .srqOut(srqOut)
  );

  function automatic logic [7:0] expSb();
    logic [7:0] s;
    s = 8'h00;
    s[2] = errQueueNotEmpty;
    s[3] = |(quesEvent & quesEnable);
    s[4] = msgAvail;
    s[5] = |(stdEvent & stdEnable);
    s[7] = |(operEvent & operEnable);
    s[6] = |(s & sreModel & 8'hBF);
    return s;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeSre(input logic [7:0] v);
    sreWrEn = 1; sreWrData = v;
    tick(1);
    sreWrEn = 0;
    sreModel = v & 8'hBF;
  endtask

  task automatic idle();
    errQueueNotEmpty = 0; errEntered = 0; msgAvail = 0;
    quesEvent = '0; quesEnable = '0; operEvent = '0; operEnable = '0;
    stdEvent = '0; stdEnable = '0;
    writeSre(8'h00);
    srqClear = 1; tick(1); srqClear = 0; tick(1);
  endtask

  task automatic testReset();
    check(sreRdData, 8'h00, "R11 mask after reset");
    check({7'b0, srqOut}, 8'h00, "R11 request after reset");
    check(statusByte, 8'h00, "R11 status after reset");
  endtask

  task automatic testMaskWrite();
    writeSre(8'hFF);
    check(sreRdData, 8'hBF, "R5 write all ones");
    writeSre(8'h40);
    check(sreRdData, 8'h00, "R5 bit6 only write");
    check(statusByte, 8'h00, "R1 low bits zero idle");
    idle();
  endtask

  task automatic testAssembly();
    errQueueNotEmpty = 1; msgAvail = 1;
    quesEvent = 16'h0100; quesEnable = 16'h0100;
    stdEvent = 8'h05; stdEnable = 8'h02;
    operEvent = 16'h8000; operEnable = 16'h8001;
    tick(1);
    check(statusByte, expSb(), "R2 R3 mixed assembly");
    check(statusByte & 8'h03, 8'h00, "R1 low bits zero busy");
    stdEnable = 8'h04; quesEnable = 16'h0001;
    tick(1);
    check(statusByte, expSb(), "R3 std on ques off");
    idle();
  endtask

  task automatic testSummary();
    operEvent = 16'h0010; operEnable = 16'h0010;
    writeSre(8'h08);
    check(statusByte, 8'h80, "R4 enabled bit not set");
    writeSre(8'h88);
    check(statusByte, 8'hC0, "R4 summary set");
    writeSre(8'h00);
    check(statusByte, 8'h80, "R4 summary cleared");
    idle();
  endtask

  task automatic testRiseAndClear();
    writeSre(8'h10);
    msgAvail = 1;
    tick(1);
    check({7'b0, srqOut}, 8'h01, "R6 request on rise");
    srqClear = 1; tick(1); srqClear = 0;
    check({7'b0, srqOut}, 8'h00, "R9 cleared by host");
    tick(4);
    check({7'b0, srqOut}, 8'h00, "R7 no repeat while high");
    msgAvail = 0; tick(1);
    msgAvail = 1; tick(1);
    check({7'b0, srqOut}, 8'h01, "R6 request on second rise");
    msgAvail = 0; tick(1);
    check({7'b0, srqOut}, 8'h00, "R9 drop when summary clears");
    idle();
  endtask

  task automatic testDisabled();
    writeSre(8'h80);
    msgAvail = 1; stdEvent = 8'h01; stdEnable = 8'h01;
    tick(2);
    check({7'b0, srqOut}, 8'h00, "R10 masked rise ignored");
    check(statusByte, 8'h30, "R10 status shows bits");
    idle();
  endtask

  task automatic testErrorEntries();
    writeSre(8'h04);
    errQueueNotEmpty = 1; errEntered = 1; tick(1); errEntered = 0;
    check({7'b0, srqOut}, 8'h01, "R8 first error entry");
    srqClear = 1; tick(1); srqClear = 0;
    check({7'b0, srqOut}, 8'h00, "R9 clear after error");
    tick(2);
    errEntered = 1; tick(1); errEntered = 0;
    check({7'b0, srqOut}, 8'h01, "R8 second entry queue non-empty");
    srqClear = 1; tick(1); srqClear = 0;
    writeSre(8'h00);
    errEntered = 1; tick(1); errEntered = 0;
    check({7'b0, srqOut}, 8'h00, "R10 entry with bit2 masked");
    idle();
  endtask

  initial begin
    tick(3);
    rstN = 1;
    tick(1);
    testReset();
    testMaskWrite();
    testAssembly();
    testSummary();
    testRiseAndClear();
    testDisabled();
    testErrorEntries();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule